// File: doc/BRIEF.md
# Storage Command Statistics Accumulator

This block keeps usage statistics for one namespace of a storage controller. Each time a command completes, it receives the command opcode, a zero-based block count and the current number of used blocks in the namespace. Read and write commands are counted separately. Each counter is held as a pair of words, low and high. The block counts of each direction are collected in a residual accumulator. Every full group of `DU_BLOCKS` blocks (1000 by default) that the accumulator collects adds one data unit to that direction's data-unit counter, and the accumulator keeps only the leftover blocks.

A single repeated subtractor does the division by the group size. It takes one unit per cycle, and `cmd_ready` stays low until it finishes. A write that changes the used-block count can raise a one-shot spare-capacity warning. This happens when the integer percentage of free blocks falls below a programmable threshold. The warning is a single-cycle strobe with an event code. After it fires, a sticky flag blocks further warnings until reset or until the host pulses a clear input. The counters are read through a register-select port.

Top module: `stat_accum`

## Requirements
- R1: Only opcode 0x01 (write) and opcode 0x02 (read) update statistics. Any other accepted opcode leaves every counter, the residuals and `cmd_ready` unchanged.
- R2: Each accepted write or read adds one to the low word of that direction's command counter. The high word adds one exactly when the low word wraps to zero.
- R3: Each accepted write or read adds `cmd_nlb + 1` blocks to that direction's residual accumulator.
- R4: The data-unit counter of the command's direction advances by floor(residual / `DU_BLOCKS`), and the residual keeps the remainder. `cmd_ready` stays low until this is done.
- R5: A data-unit high word adds one exactly when the new low word is smaller than the old one, that is, when the low word wraps.
- R6: An accepted write fires the warning when three conditions all hold: its `ns_used` differs from the `ns_used` of the previous accepted write (zero after reset), the sticky flag is clear, and 100 − floor(100·`ns_used`/`ns_size`) < `thresh_pct`. The warning is `evt_pulse` high for the one cycle after acceptance, with `evt_code` = `EVT_SPARE` (0x02 by default). At all other times `evt_code` is zero.
- R7: Once the warning has fired, no further warning fires until reset or a `warn_clr` pulse. Read commands never fire it.
- R8: `rd_sel` selects a word: 0 write-command low, 1 write-command high, 2 read-command low, 3 read-command high, 4 write-data-unit low, 5 write-data-unit high, 6 read-data-unit low, 7 read-data-unit high. Values 8 to 15 read zero.
- R9: After reset every counter and residual is zero, `cmd_ready` is high and `evt_pulse` is low.
- R10: A `cmd_valid` presented while `cmd_ready` is low is not taken and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Completed command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 8 | Command opcode |
| cmd_nlb | input | NLB_W | Zero-based block count |
| ns_used | input | UW | Used blocks in the namespace |
| ns_size | input | UW | Total blocks in the namespace |
| thresh_pct | input | 7 | Free-capacity warning threshold, 0 to 100 |
| warn_clr | input | 1 | Clears the sticky warning flag |
| rd_sel | input | 4 | Counter word select |
| rd_data | output | CW | Selected counter word |
| evt_pulse | output | 1 | Warning event strobe |
| evt_code | output | 8 | Event code while strobe is high |

## Verification
The bench is built with 4-bit counter words. A swept series of mixed reads, writes and foreign opcodes, with block counts spread over the full count range, drives both command and data-unit words through several wraps. This exposes any error in the high-word carry and any wrong residual remainder. A complete sweep of used-block values from 0 to the namespace size, at two thresholds, tells the exact point where the percentage comparison flips apart from an off-by-one error. Unchanged used counts, repeated writes after the warning, and reads with a high used count separate the one-shot rule from a level-based warning. A command offered while the divider is busy shows whether the block wrongly takes input during the division.

// File: rtl/stat_accum.sv
`timescale 1ns/1ps
module stat_accum #(
  parameter int CW = 64,
  parameter int NLB_W = 16,
  parameter int UW = 32,
  parameter int DU_BLOCKS = 1000,
  parameter logic [7:0] OP_WR = 8'h01,
  parameter logic [7:0] OP_RD = 8'h02,
  parameter logic [7:0] EVT_SPARE = 8'h02
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_op,
  input  logic [NLB_W-1:0] cmd_nlb,
  input  logic [UW-1:0]    ns_used,
  input  logic [UW-1:0]    ns_size,
  input  logic [6:0]       thresh_pct,
  input  logic             warn_clr,
  input  logic [3:0]       rd_sel,
  output logic [CW-1:0]    rd_data,
  output logic             evt_pulse,
  output logic [7:0]       evt_code
);
  localparam int ACC_W = $clog2(DU_BLOCKS + (1 << NLB_W));
  localparam int PW = UW + 8;
  localparam logic [ACC_W-1:0] UNIT = ACC_W'(DU_BLOCKS);

  logic busy, dir_wr, warned, evt_q;
  logic [ACC_W-1:0] acc_wr, acc_rd;
  logic [CW-1:0] wc_lo, wc_hi, rc_lo, rc_hi, wu_lo, wu_hi, ru_lo, ru_hi;
  logic [UW-1:0] used_q;

  wire take  = cmd_valid && !busy;
  wire is_wr = cmd_op == OP_WR;
  wire is_rd = cmd_op == OP_RD;
  wire [ACC_W-1:0] blk_add = ACC_W'(cmd_nlb) + ACC_W'(1);
  wire [ACC_W-1:0] acc_cur = dir_wr ? acc_wr : acc_rd;
  wire unit_due = acc_cur >= UNIT;

  wire [PW-1:0] used_x = PW'(ns_used) * PW'(100);
  wire [PW-1:0] size_x = PW'(ns_size) * PW'(8'd101 - {1'b0, thresh_pct});
  wire spare_low = used_x >= size_x;
  wire fire = take && is_wr && (ns_used != used_q) && !warned && spare_low;

  wire [CW-1:0] wc_nx = wc_lo + CW'(1);
  wire [CW-1:0] rc_nx = rc_lo + CW'(1);
  wire [CW-1:0] wu_nx = wu_lo + CW'(1);
  wire [CW-1:0] ru_nx = ru_lo + CW'(1);

  assign cmd_ready = !busy;
  assign evt_pulse = evt_q;
  assign evt_code  = evt_q ? EVT_SPARE : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; dir_wr <= 1'b0; warned <= 1'b0; evt_q <= 1'b0;
      acc_wr <= '0; acc_rd <= '0; used_q <= '0;
      wc_lo <= '0; wc_hi <= '0; rc_lo <= '0; rc_hi <= '0;
      wu_lo <= '0; wu_hi <= '0; ru_lo <= '0; ru_hi <= '0;
    end else begin
      evt_q <= fire;
      if (fire) warned <= 1'b1;
      else if (warn_clr) warned <= 1'b0;

      if (take && is_wr) begin
        used_q <= ns_used;
        wc_lo <= wc_nx;
        if (wc_nx < wc_lo) wc_hi <= wc_hi + CW'(1);
        acc_wr <= acc_wr + blk_add;
        dir_wr <= 1'b1;
        busy <= 1'b1;
      end else if (take && is_rd) begin
        rc_lo <= rc_nx;
        if (rc_nx < rc_lo) rc_hi <= rc_hi + CW'(1);
        acc_rd <= acc_rd + blk_add;
        dir_wr <= 1'b0;
        busy <= 1'b1;
      end

      if (busy) begin
        if (!unit_due) busy <= 1'b0;
        else if (dir_wr) begin
          acc_wr <= acc_wr - UNIT;
          wu_lo <= wu_nx;
          if (wu_nx < wu_lo) wu_hi <= wu_hi + CW'(1);
        end else begin
          acc_rd <= acc_rd - UNIT;
          ru_lo <= ru_nx;
          if (ru_nx < ru_lo) ru_hi <= ru_hi + CW'(1);
        end
      end
    end
  end

  always_comb begin
    case (rd_sel)
      4'd0: rd_data = wc_lo;
      4'd1: rd_data = wc_hi;
      4'd2: rd_data = rc_lo;
      4'd3: rd_data = rc_hi;
      4'd4: rd_data = wu_lo;
      4'd5: rd_data = wu_hi;
      4'd6: rd_data = ru_lo;
      4'd7: rd_data = ru_hi;
      default: rd_data = '0;
    endcase
  end

  p_res_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (acc_wr < UNIT) && (acc_rd < UNIT));
  p_other_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take && !is_wr && !is_rd |=> $stable(wc_lo) && $stable(rc_lo) &&
      $stable(wu_lo) && $stable(ru_lo) && $stable(acc_wr) && $stable(acc_rd) && !busy);
  p_cmd_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_wr |=> wc_lo == $past(wc_lo) + CW'(1));
  p_cmd_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wc_hi) |-> wc_lo == '0);
  p_du_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wu_hi) || !$stable(ru_hi) |-> (wu_lo == '0) || (ru_lo == '0));
  p_evt_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |=> !evt_q);
  p_evt_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> warned);
  p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> $stable(wc_lo) && $stable(rc_lo) && $stable(used_q));
endmodule

// File: tb/sim_stat_accum.sv
`timescale 1ns/1ps
module sim_stat_accum;
  localparam int CW = 4, NLB_W = 12, UW = 8;
  logic clk = 0, rst_n = 0, cmd_valid = 0, warn_clr = 0;
  logic cmd_ready, evt_pulse;
  logic [7:0] cmd_op = 0, evt_code;
  logic [NLB_W-1:0] cmd_nlb = 0;
  logic [UW-1:0] ns_used = 0, ns_size = 100;
  logic [6:0] thresh_pct = 0;
  logic [3:0] rd_sel = 0;
  logic [CW-1:0] rd_data;
  int total = 0, bad = 0;
  int wc = 0, rc = 0, wu = 0, ru = 0, wacc = 0, racc = 0, prev_used = 0;
  bit warned_m = 0, done = 0;

  always #5 clk = ~clk;

  stat_accum #(.CW(CW), .NLB_W(NLB_W), .UW(UW)) u0 (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_nlb, .ns_used, .ns_size,
    .thresh_pct, .warn_clr, .rd_sel, .rd_data, .evt_pulse, .evt_code);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    int exp [8];
    exp[0] = wc % 16; exp[1] = (wc / 16) % 16;
    exp[2] = rc % 16; exp[3] = (rc / 16) % 16;
    exp[4] = wu % 16; exp[5] = (wu / 16) % 16;
    exp[6] = ru % 16; exp[7] = (ru / 16) % 16;
    for (int s = 0; s < 8; s++) begin
      rd_sel = 4'(s);
      #1;
      chk(int'(rd_data) == exp[s], $sformatf("%s sel%0d", tag, s), int'(rd_data), exp[s]);
    end
  endtask

  task automatic model(input logic [7:0] op, input int nlb, input int used, output bit f);
    f = (op == 8'h01) && (used != prev_used) && !warned_m &&
        ((100 - (used * 100) / int'(ns_size)) < int'(thresh_pct));
    if (op == 8'h01) begin
      wc++; wacc += nlb + 1; wu += wacc / 1000; wacc %= 1000; prev_used = used;
    end else if (op == 8'h02) begin
      rc++; racc += nlb + 1; ru += racc / 1000; racc %= 1000;
    end
    if (f) warned_m = 1;
  endtask

  task automatic send(input logic [7:0] op, input int nlb, input int used, input bit hold_test);
    bit f;
    model(op, nlb, used, f);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_nlb = NLB_W'(nlb); ns_used = UW'(used);
    @(negedge clk);
    cmd_valid = hold_test;
    if (hold_test) begin
      cmd_op = 8'h02; ns_used = UW'(used + 7);
    end
    chk(evt_pulse == f, "R6 event strobe", int'(evt_pulse), int'(f));
    if (f) chk(evt_code == 8'h02, "R6 event code", int'(evt_code), 2);
    else chk(evt_code == 8'h00, "R6 idle code", int'(evt_code), 0);
    if (hold_test) begin
      @(negedge clk);
      cmd_valid = 0;
    end
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); warn_clr = 1;
    @(negedge clk); warn_clr = 0;
    warned_m = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(cmd_ready == 1, "R9 ready", int'(cmd_ready), 1);
    chk(evt_pulse == 0, "R9 event", int'(evt_pulse), 0);
    check_regs("R9 reset");
    // R2 R3 R4 R5 R1: mixed sweep
    for (int i = 0; i < 48; i++) begin
      logic [7:0] op;
      op = (i % 6 == 5) ? 8'(8'h10 + i) : ((i % 3 == 0) ? 8'h02 : 8'h01);
      send(op, (i * 523 + 17) % 4096, 0, 0);
      check_regs((op != 8'h01 && op != 8'h02) ? "R1 foreign op" : "R2 R4 R5 sweep");
      chk(cmd_ready == 1, "R1 ready after", int'(cmd_ready), 1);
    end
    // R3 exact group boundaries
    send(8'h01, 998 - wacc < 0 ? 0 : 998 - wacc, 0, 0);
    check_regs("R3 boundary");
    send(8'h01, 0, 0, 0);
    check_regs("R3 boundary plus one");
    send(8'h02, 4095, 0, 0);
    check_regs("R3 max count");
    // R10 command offered while busy
    send(8'h01, 4000, 0, 1);
    check_regs("R10 busy offer");
    // R8 unused selects
    for (int s = 8; s < 16; s++) begin
      rd_sel = 4'(s);
      #1;
      chk(rd_data == '0, "R8 unused select", int'(rd_data), 0);
    end
    // R6 exhaustive used sweep at two thresholds
    ns_size = 50;
    for (int t = 0; t < 2; t++) begin
      thresh_pct = (t == 0) ? 7'd10 : 7'd30;
      for (int u = 0; u <= 50; u++) begin
        pulse_clr();
        send(8'h01, 0, u, 0);
      end
    end
    check_regs("R6 sweep counters");
    // R7 sticky flag
    thresh_pct = 7'd30;
    pulse_clr();
    send(8'h01, 0, 45, 0);
    send(8'h01, 0, 46, 0);
    send(8'h01, 0, 48, 0);
    send(8'h02, 0, 49, 0);
    pulse_clr();
    send(8'h01, 0, 48, 0);
    send(8'h02, 0, 47, 0);
    send(8'h01, 0, 47, 0);
    chk(warned_m == 1, "R7 model flag", int'(warned_m), 1);
    check_regs("R7 counters");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule